// File: doc/BRIEF.md
# Interpolating Phase-to-Sine Generator

This block is a direct digital synthesis sine source. A phase register advances by a programmable tuning word on every enabled clock and wraps modulo 2^PHASE_W. The upper phase bits address a sine table that holds one full period. Two copies of the table are read in the same cycle, one at the truncated address and one at the next address. The next phase bits below the address field form a fraction, and that fraction weights a linear blend between the two neighbouring entries. This gives a much smaller phase-truncation error than a plain truncating lookup.

The table is computed when the design is elaborated, so no initialisation file is needed. The datapath has a fixed three-stage pipeline: phase capture, table read, then blend and round. A valid flag travels alongside the data. A surrounding design drives `en` for each sample it wants and receives that sample three clocks later.

Top module: `sine_dds_interp`

## Requirements
- R1: A synchronous reset clears the phase to zero, drops every sample still in flight, and leaves `sampleValid` low and `sampleOut` at zero. The first sample after reset uses phase zero.
- R2: The phase used for the n-th enabled cycle after reset (n counted from 0) is the sum of the tuning words applied on the earlier enabled cycles, modulo 2^PHASE_W. On a cycle with `en` low, the phase does not advance.
- R3: `sampleValid` rises in the third rising edge counted from the edge that captures `en` high, and only then. `sampleOut` holds its value in every cycle where `sampleValid` is low.
- R4: With phase p, the address a is p[PHASE_W-1 -: ADDR_W] and the fraction f is the next FRAC_W bits below the address. The output is floor((256·A + (B−A)·f + 128) / 256), written for FRAC_W = 8, where A is entry a and B is entry a+1.
- R5: The neighbour of the last table entry is entry 0, so phases in the last address interval blend toward entry 0.
- R6: Entry k holds round(32767·sin(2πk/2^ADDR_W)), with halves rounded away from zero. A phase with f = 0 outputs that entry exactly.
- R7: Every output is within 3 LSB of 32767·sin(2π·p/2^PHASE_W) for its full phase p.
- R8: Outputs stay inside the symmetric range ±(2^(DATA_W−1)−1) and never take the most negative code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Produce one sample and advance the phase |
| tuneWord | input | PHASE_W | Phase increment per enabled clock |
| sampleOut | output | DATA_W | Signed sine sample |
| sampleValid | output | 1 | `sampleOut` carries a new sample this cycle |

## Verification
The bench uses the default parameters: a 24-bit phase, a 1024-entry table, an 8-bit fraction and 16-bit samples. These bring the following cases within a few thousand cycles:
- A tuning word of 2^14 lands on every table entry exactly once per period.
- A step of minus half an entry visits the last address interval on the second sample, which exercises the wrap to entry 0.
- An irregular tuning word sweeps fractions and addresses widely enough to test the error bound against a real-valued sine.

// File: rtl/sine_dds_pkg.sv
package sine_dds_pkg;

  localparam int PIPE_LAT = 3;

  typedef struct packed {
    logic advance;
    logic readStb;
    logic outStb;
  } dds_strobe_t;

  function automatic int sinEntry(input int k, input int addrW, input int dataW);
    real ang;
    real amp;
    real x;
    ang = 2.0 * 3.14159265358979323846 * real'(k) / (2.0 ** addrW);
    amp = (2.0 ** (dataW - 1)) - 1.0;
    x   = amp * $sin(ang);
    if (x >= 0.0) return $rtoi(x + 0.5);
    else          return -$rtoi(0.5 - x);
  endfunction

endpackage

// File: rtl/sine_dds_ctrl.sv
module sine_dds_ctrl
  import sine_dds_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  output dds_strobe_t stb,
  output logic        sampleValid
);

  logic [PIPE_LAT-1:0] vPipe;

  always_ff @(posedge clk) begin
    if (rst) vPipe <= '0;
    else     vPipe <= {vPipe[PIPE_LAT-2:0], en};
  end

  always_comb begin
    stb.advance = en;
    stb.readStb = vPipe[0];
    stb.outStb  = vPipe[1];
  end

  assign sampleValid = vPipe[PIPE_LAT-1];

endmodule

// File: rtl/sine_dds_dp.sv
module sine_dds_dp
  import sine_dds_pkg::*;
#(
  parameter int PHASE_W = 24,
  parameter int ADDR_W  = 10,
  parameter int FRAC_W  = 8,
  parameter int DATA_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  dds_strobe_t              stb,
  input  logic [PHASE_W-1:0]       tuneWord,
  output logic signed [DATA_W-1:0] sampleOut
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int SUM_W = DATA_W + FRAC_W + 2;
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((64'sd1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] MINV = -MAXV;
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(64'sd1 <<< (FRAC_W - 1));

  logic [PHASE_W-1:0] phase;
  logic [ADDR_W-1:0]  addrA, addrB;
  logic [FRAC_W-1:0]  frac1, frac2;
  logic signed [DATA_W-1:0] valA, valB;
  logic signed [DATA_W-1:0] rom [2][DEPTH];

  for (genvar c = 0; c < 2; c++) begin : g_copy
    for (genvar k = 0; k < DEPTH; k++) begin : g_ent
      assign rom[c][k] = DATA_W'(sinEntry(k, ADDR_W, DATA_W));
    end
  end

  // stage 1: capture phase, advance accumulator
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      addrA <= '0;
      frac1 <= '0;
    end else if (stb.advance) begin
      phase <= phase + tuneWord;
      addrA <= phase[PHASE_W-1 -: ADDR_W];
      frac1 <= phase[PHASE_W-ADDR_W-1 -: FRAC_W];
    end
  end

  assign addrB = addrA + 1'b1;

  // stage 2: dual table read
  always_ff @(posedge clk) begin
    if (rst) begin
      valA  <= '0;
      valB  <= '0;
      frac2 <= '0;
    end else if (stb.readStb) begin
      valA  <= rom[0][addrA];
      valB  <= rom[1][addrB];
      frac2 <= frac1;
    end
  end

  // stage 3: blend, round, clamp
  logic signed [SUM_W-1:0] diff, fracS, blend, shifted, clamped;

  always_comb begin
    diff    = SUM_W'(valB) - SUM_W'(valA);
    fracS   = signed'(SUM_W'(frac2));
    blend   = (SUM_W'(valA) <<< FRAC_W) + diff * fracS + HALF;
    shifted = blend >>> FRAC_W;
    if (shifted > MAXV)      clamped = MAXV;
    else if (shifted < MINV) clamped = MINV;
    else                     clamped = shifted;
  end

  always_ff @(posedge clk) begin
    if (rst)             sampleOut <= '0;
    else if (stb.outStb) sampleOut <= clamped[DATA_W-1:0];
  end

endmodule

// File: rtl/sine_dds_interp.sv
module sine_dds_interp
  import sine_dds_pkg::*;
#(
  parameter int PHASE_W = 24,
  parameter int ADDR_W  = 10,
  parameter int FRAC_W  = 8,
  parameter int DATA_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic [PHASE_W-1:0]       tuneWord,
  output logic signed [DATA_W-1:0] sampleOut,
  output logic                     sampleValid
);

  dds_strobe_t stb;

  sine_dds_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .stb         (stb),
    .sampleValid (sampleValid)
  );

  sine_dds_dp #(
    .PHASE_W (PHASE_W),
    .ADDR_W  (ADDR_W),
    .FRAC_W  (FRAC_W),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .tuneWord  (tuneWord),
    .sampleOut (sampleOut)
  );

endmodule

// File: rtl/sine_dds_checker.sv
module sine_dds_checker #(
  parameter int DATA_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     en,
  input logic signed [DATA_W-1:0] sampleOut,
  input logic                     sampleValid
);

  localparam logic signed [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!sampleValid && sampleOut == '0));

  // R3
  a_r3_latency: assert property (@(posedge clk) disable iff (rst)
    en |-> ##3 sampleValid);

  // R3
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !en |-> ##3 !sampleValid);

  // R3
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!sampleValid && !$past(rst)) |-> $stable(sampleOut));

  // R8
  a_r8_symmetric: assert property (@(posedge clk) disable iff (rst)
    sampleValid |-> sampleOut != MOST_NEG);

endmodule

bind sine_dds_interp sine_dds_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .en          (en),
  .sampleOut   (sampleOut),
  .sampleValid (sampleValid)
);

// File: tb/sine_dds_interp_tb.sv
`timescale 1ns/1ps
module sine_dds_interp_tb;

  localparam int PHASE_W = 24;
  localparam int ADDR_W  = 10;
  localparam int FRAC_W  = 8;
  localparam int DATA_W  = 16;
  localparam int LAT     = 3;
  localparam int PMOD    = 1 << PHASE_W;

  typedef struct { int ph; int edgeNo; } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [PHASE_W-1:0] tuneWord = '0;
  logic signed [DATA_W-1:0] sampleOut;
  logic sampleValid;

  int nTests = 0;
  int nFail  = 0;
  int edgeCnt = 0;
  int modelPhase = 0;
  string tag = "R1";
  exp_t q[$];

  sine_dds_interp #(
    .PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)
  ) u_dut (
    .clk(clk), .rst(rst), .en(en), .tuneWord(tuneWord),
    .sampleOut(sampleOut), .sampleValid(sampleValid)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    edgeCnt <= edgeCnt + 1;
    if (edgeCnt > 100000) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", edgeCnt);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int tblVal(input int k);
    real x;
    x = 32767.0 * $sin(2.0 * 3.14159265358979323846 * real'(k) / real'(1 << ADDR_W));
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(0.5 - x);
  endfunction

  function automatic int expSample(input int ph);
    int a, b, f, v;
    a = (ph >> (PHASE_W - ADDR_W)) & ((1 << ADDR_W) - 1);
    f = (ph >> (PHASE_W - ADDR_W - FRAC_W)) & 255;
    b = (a + 1) & ((1 << ADDR_W) - 1);
    v = 256 * tblVal(a) + (tblVal(b) - tblVal(a)) * f + 128;
    return v >>> 8;
  endfunction

  // monitor away from the active edge
  always @(negedge clk) begin
    if (!rst && sampleValid) begin
      if (q.size() == 0) begin
        check(1'b0, {tag, " R3 unexpected valid"}, 1, 0);
      end else begin
        exp_t e;
        real ideal, err;
        int act;
        e = q.pop_front();
        act = int'(sampleOut);
        check(edgeCnt == e.edgeNo, {tag, " R3 latency edge"}, edgeCnt, e.edgeNo);
        check(act == expSample(e.ph), {tag, " R4 value"}, act, expSample(e.ph));
        ideal = 32767.0 * $sin(2.0 * 3.14159265358979323846 * real'(e.ph) / real'(PMOD));
        err = real'(act) - ideal;
        if (err < 0.0) err = -err;
        check(err <= 3.0, {tag, " R7 accuracy"}, act, $rtoi(ideal));
        check(act != -32768, {tag, " R8 range"}, act, -32767);
      end
    end
  end

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    en  = 1'b0;
    q.delete();
    modelPhase = 0;
    repeat (3) @(negedge clk);
    check(sampleValid == 1'b0, "R1 valid low in reset", int'(sampleValid), 0);
    check(sampleOut == '0, "R1 output zero in reset", int'(sampleOut), 0);
    rst = 1'b0;
  endtask

  // drive n cycles; every gapEvery-th cycle (if nonzero) has en low
  task automatic runSamples(input int n, input int tw, input int gapEvery);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tuneWord = PHASE_W'(tw);
      if (gapEvery != 0 && (i % gapEvery) == gapEvery - 1) begin
        en = 1'b0;
      end else begin
        exp_t e;
        en = 1'b1;
        e.ph = modelPhase;
        e.edgeNo = edgeCnt + LAT;
        q.push_back(e);
        modelPhase = (modelPhase + tw) & (PMOD - 1);
      end
    end
    @(negedge clk);
    en = 1'b0;
    repeat (LAT + 2) @(negedge clk);
    check(q.size() == 0, {tag, " R3 all samples delivered"}, q.size(), 0);
  endtask

  task automatic testReset();
    tag = "R1";
    doReset();
    @(negedge clk);
    check(sampleValid == 1'b0, "R1 idle after reset", int'(sampleValid), 0);
    runSamples(4, 1 << 14, 0);
    // mid-stream reset kills in-flight samples and restarts phase
    @(negedge clk);
    en = 1'b1;
    tuneWord = 24'h0F0F0F;
    @(negedge clk);
    en = 1'b0;
    doReset();
    repeat (4) begin
      @(negedge clk);
      check(sampleValid == 1'b0, "R1 no stale sample", int'(sampleValid), 0);
    end
    runSamples(3, 24'h012345, 0);
  endtask

  task automatic testTable();
    tag = "R6";
    doReset();
    runSamples(1030, 1 << 14, 0);
  endtask

  task automatic testWrap();
    tag = "R5";
    doReset();
    runSamples(40, PMOD - (1 << 13), 0);
    tag = "R5b";
    doReset();
    runSamples(20, PMOD - 24'h0000A7, 0);
  endtask

  task automatic testGaps();
    tag = "R2";
    doReset();
    runSamples(300, 24'h0ABCDE, 3);
    runSamples(100, 24'h7FFFFF, 2);
  endtask

  task automatic testSweep();
    tag = "R7";
    doReset();
    runSamples(2000, 24'h123457, 0);
    runSamples(500, 24'h000101, 0);
  endtask

  initial begin
    testReset();
    testTable();
    testWrap();
    testGaps();
    testSweep();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule